// File: doc/BRIEF.md
# Power-Phase Sequencer for a Pulsed Readout Chip

This block steps a readout chip through four operating phases and drives one control per power domain from the current phase. The domains are the preamplifier, the shaper, the converter, the signal processor, the buffer memory, the configuration registers and the link port. The converter has two controls: its bias and its clock.

Phase changes come from fast synchronous commands that arrive over the link port. Each command is decoded upstream into a one-cycle strobe and a small code. The actual bias and supply switches sit outside the block and follow its outputs.

While the logic domains sleep, the configuration registers are kept at a retention supply level. They are not switched off. The converter clock starts only after its bias has settled for a programmable number of cycles.

Top module: `pp_phase_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in the sleep phase (phase code 3), with the converter warm-up count cleared.
- R2: A strobe carrying a valid code moves the block, at that clock edge, to the named phase. The codes are 1 for sampling, 2 for non-sampling, 3 for read and 4 for sleep. The phase output codes are 0 for sampling, 1 for non-sampling, 2 for read and 3 for sleep.
- R3: A strobe carrying any other code (0 or 5 to 15) leaves the phase and every domain output unchanged. A valid code presented without the strobe also leaves them unchanged.
- R4: In the sampling phase the following outputs are all high: preamplifier, shaper, converter bias, signal processor, memory, full configuration supply and link port. Retention is low.
- R5: In the non-sampling and read phases, preamplifier, shaper, converter bias and converter clock are low. Signal processor, memory, full configuration supply and link port are high, and retention is low.
- R6: In the sleep phase, preamplifier, shaper, converter bias, converter clock, signal processor and memory are low. Retention and link port are high, and the full configuration supply is low.
- R7: The converter clock enable goes high exactly WARM clock edges after the converter bias rises, and stays high while the bias stays high. It is never high while the bias is low. If the bias drops during the warm-up, the count restarts.
- R8: Exactly one of the full configuration supply and the retention output is high. Retention is high exactly when the signal processor is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_stb | input | 1 | One-cycle strobe of a decoded fast command |
| cmd_code | input | CMD_W | Command code, valid with cmd_stb |
| pre_en | output | 1 | Preamplifier bias enable |
| shp_en | output | 1 | Shaper bias enable |
| adc_bias_en | output | 1 | Converter bias enable |
| adc_clk_en | output | 1 | Converter clock gate enable |
| dsp_en | output | 1 | Signal processor supply enable |
| mem_en | output | 1 | Buffer memory supply enable |
| cfg_on | output | 1 | Configuration registers at full supply |
| cfg_ret | output | 1 | Configuration registers at retention supply |
| link_en | output | 1 | Link port supply enable |
| phase | output | 2 | Current phase code |

## Verification
The checker tests several properties on every cycle. The converter clock never runs without bias. The clock enable matches an independent count of consecutive bias cycles. Exactly one configuration supply level is active. The sleep phase always has the logic off and retention on. The phase holds when no strobe arrives.

The bench's sweep covers the rest. It tries every code from every starting phase, which shows how unknown codes are ignored and maps each phase to its domain pattern. Separate scenarios show warm-up aborts and repeated sampling commands.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_IDLE   = 2'd1,
        PH_READ   = 2'd2,
        PH_SLEEP  = 2'd3
    } phase_e;

    localparam int CODE_SAMPLE = 1;
    localparam int CODE_IDLE   = 2;
    localparam int CODE_READ   = 3;
    localparam int CODE_SLEEP  = 4;

    typedef struct packed {
        logic pre;
        logic shp;
        logic bias;
        logic dsp;
        logic mem;
        logic cfg_on;
        logic cfg_ret;
        logic link;
    } dom_t;

    // Domain pattern of a phase; retention follows the logic domain.
    function automatic dom_t dom_for(input phase_e p);
        dom_t d;
        d.pre     = (p == PH_SAMPLE);
        d.shp     = (p == PH_SAMPLE);
        d.bias    = (p == PH_SAMPLE);
        d.dsp     = (p != PH_SLEEP);
        d.mem     = (p != PH_SLEEP);
        d.cfg_on  = d.dsp;
        d.cfg_ret = !d.dsp;
        d.link    = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/pp_cmd_dec.sv
module pp_cmd_dec
    import pp_pkg::*;
#(
    parameter int CMD_W = 4
) (
    input  logic             cmd_stb,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             hit,
    output phase_e           ph_next
);
    always_comb begin
        hit     = 1'b0;
        ph_next = PH_SLEEP;
        if (cmd_stb) begin
            if (cmd_code == CMD_W'(CODE_SAMPLE)) begin
                hit = 1'b1; ph_next = PH_SAMPLE;
            end else if (cmd_code == CMD_W'(CODE_IDLE)) begin
                hit = 1'b1; ph_next = PH_IDLE;
            end else if (cmd_code == CMD_W'(CODE_READ)) begin
                hit = 1'b1; ph_next = PH_READ;
            end else if (cmd_code == CMD_W'(CODE_SLEEP)) begin
                hit = 1'b1; ph_next = PH_SLEEP;
            end
        end
    end
endmodule

// File: rtl/pp_phase_reg.sv
module pp_phase_reg
    import pp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  phase_e ph_next,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_SLEEP;
        else if (hit)
            phase <= ph_next;
    end
endmodule

// File: rtl/pp_adc_warm.sv
module pp_adc_warm #(
    parameter int WARM = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bias_en,
    output logic clk_en
);
    localparam int CNT_W = $clog2(WARM + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WARM - 1);

    logic [CNT_W-1:0] cnt;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst || !bias_en) begin
            cnt   <= '0;
            run_q <= 1'b0;
        end else if (cnt == LAST) begin
            run_q <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Gate with the live bias so the clock stops in the same cycle.
    assign clk_en = run_q & bias_en;
endmodule

// File: rtl/pp_phase_ctrl.sv
module pp_phase_ctrl
    import pp_pkg::*;
#(
    parameter int CMD_W = 4,
    parameter int WARM  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_stb,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             pre_en,
    output logic             shp_en,
    output logic             adc_bias_en,
    output logic             adc_clk_en,
    output logic             dsp_en,
    output logic             mem_en,
    output logic             cfg_on,
    output logic             cfg_ret,
    output logic             link_en,
    output logic [1:0]       phase
);
    logic   hit;
    phase_e ph_next;
    phase_e ph_q;
    dom_t   dom;

    pp_cmd_dec #(.CMD_W(CMD_W)) u_dec (
        .cmd_stb (cmd_stb),
        .cmd_code(cmd_code),
        .hit     (hit),
        .ph_next (ph_next)
    );

    pp_phase_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .ph_next(ph_next),
        .phase  (ph_q)
    );

    assign dom = dom_for(ph_q);

    pp_adc_warm #(.WARM(WARM)) u_warm (
        .clk    (clk),
        .rst    (rst),
        .bias_en(dom.bias),
        .clk_en (adc_clk_en)
    );

    assign pre_en      = dom.pre;
    assign shp_en      = dom.shp;
    assign adc_bias_en = dom.bias;
    assign dsp_en      = dom.dsp;
    assign mem_en      = dom.mem;
    assign cfg_on      = dom.cfg_on;
    assign cfg_ret     = dom.cfg_ret;
    assign link_en     = dom.link;
    assign phase       = ph_q;
endmodule

// File: rtl/pp_phase_ctrl_chk.sv
module pp_phase_ctrl_chk #(
    parameter int CMD_W = 4,
    parameter int WARM  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_stb,
    input logic [CMD_W-1:0] cmd_code,
    input logic             adc_bias_en,
    input logic             adc_clk_en,
    input logic             dsp_en,
    input logic             mem_en,
    input logic             cfg_on,
    input logic             cfg_ret,
    input logic [1:0]       phase
);
    localparam int CW = $clog2(WARM + 1);

    logic [CW-1:0] bias_run;
    always_ff @(posedge clk) begin
        if (rst || !adc_bias_en)
            bias_run <= '0;
        else if (bias_run != CW'(WARM))
            bias_run <= bias_run + 1'b1;
    end

    // R7
    clk_needs_bias_chk: assert property (@(posedge clk) disable iff (rst)
        adc_clk_en |-> adc_bias_en);

    // R7
    warm_delay_chk: assert property (@(posedge clk) disable iff (rst)
        adc_clk_en == (adc_bias_en && bias_run == CW'(WARM)));

    // R8
    cfg_level_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({cfg_on, cfg_ret}) == 1 && (cfg_ret == !dsp_en));

    // R6
    sleep_dom_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3) |-> (!dsp_en && !mem_en && !adc_bias_en && cfg_ret));

    // R3
    hold_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_stb |=> $stable(phase));

    // R2
    enter_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_code == CMD_W'(1)) |=> (phase == 2'd0));
endmodule

bind pp_phase_ctrl pp_phase_ctrl_chk #(.CMD_W(CMD_W), .WARM(WARM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_stb    (cmd_stb),
    .cmd_code   (cmd_code),
    .adc_bias_en(adc_bias_en),
    .adc_clk_en (adc_clk_en),
    .dsp_en     (dsp_en),
    .mem_en     (mem_en),
    .cfg_on     (cfg_on),
    .cfg_ret    (cfg_ret),
    .phase      (phase)
);

// File: tb/tb_pp_phase_ctrl.sv
module tb_pp_phase_ctrl;
    localparam int CMD_W = 4;
    localparam int WARM  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_stb = 1'b0;
    logic [CMD_W-1:0] cmd_code = '0;
    logic pre_en, shp_en, adc_bias_en, adc_clk_en, dsp_en, mem_en;
    logic cfg_on, cfg_ret, link_en;
    logic [1:0] phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pp_phase_ctrl #(.CMD_W(CMD_W), .WARM(WARM)) dut (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .pre_en(pre_en), .shp_en(shp_en), .adc_bias_en(adc_bias_en),
        .adc_clk_en(adc_clk_en), .dsp_en(dsp_en), .mem_en(mem_en),
        .cfg_on(cfg_on), .cfg_ret(cfg_ret), .link_en(link_en), .phase(phase)
    );

    // {pre, shp, bias, dsp, mem, cfg_on, cfg_ret, link}
    function automatic logic [7:0] exp_dom(input int p);
        case (p)
            0:       return 8'b1111_1101;
            1, 2:    return 8'b0001_1101;
            default: return 8'b0000_0011;
        endcase
    endfunction

    function automatic logic [7:0] act_dom();
        return {pre_en, shp_en, adc_bias_en, dsp_en, mem_en, cfg_on, cfg_ret, link_en};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input bit stb, input int code);
        @(negedge clk);
        cmd_stb  = stb;
        cmd_code = CMD_W'(code);
        @(negedge clk);
        cmd_stb  = 1'b0;
        cmd_code = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 phase", int'(phase), 3);
        check("R1 domains", int'(act_dom()), int'(exp_dom(3)));
        check("R1 clk", int'(adc_clk_en), 0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6 R8: every code from every start phase
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 16; c++) begin
                int exp_p;
                send(1'b1, s + 1);
                exp_p = (c >= 1 && c <= 4) ? c - 1 : s;
                send(1'b1, c);
                check((c >= 1 && c <= 4) ? "R2 phase" : "R3 phase", int'(phase), exp_p);
                check(exp_p == 0 ? "R4 domains" : (exp_p == 3 ? "R6 domains" : "R5 domains"),
                      int'(act_dom()), int'(exp_dom(exp_p)));
                check("R8 cfg", int'(cfg_on ^ cfg_ret), 1);
                if (exp_p != 0) check("R7 clk off", int'(adc_clk_en), 0);
            end
        end

        // R3: valid code without strobe
        send(1'b1, 4);
        send(1'b0, 1);
        check("R3 no strobe", int'(phase), 3);
        check("R3 no strobe dom", int'(act_dom()), int'(exp_dom(3)));

        // R7: warm-up timing
        send(1'b1, 1);
        for (int k = 0; k <= WARM + 2; k++) begin
            check("R7 warm", int'(adc_clk_en), (k >= WARM) ? 1 : 0);
            @(negedge clk);
        end
        // R7: repeated sampling command keeps the clock running
        send(1'b1, 1);
        check("R7 resend", int'(adc_clk_en), 1);
        // R7: clock drops with bias
        send(1'b1, 3);
        check("R7 drop", int'(adc_clk_en), 0);
        check("R5 read bias", int'(adc_bias_en), 0);
        // R7: aborted warm-up restarts the count
        send(1'b1, 1);
        @(negedge clk);
        send(1'b1, 2);
        send(1'b1, 1);
        for (int k = 0; k <= WARM; k++) begin
            check("R7 restart", int'(adc_clk_en), (k >= WARM) ? 1 : 0);
            @(negedge clk);
        end

        // R1: reset during sampling
        rst = 1'b1;
        @(negedge clk);
        check("R1 reapply", int'(phase), 3);
        check("R1 reapply clk", int'(adc_clk_en), 0);
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule